// File: doc/BRIEF.md
# BCD Time-of-Day and Calendar Counter

This block keeps the time of day and the calendar date in seven packed-BCD registers. A prescaler counts enable pulses from a 32.768 kHz reference and produces a one-cycle tick once per second. Each tick advances seconds, and the carries move through minutes, hours, the weekday and the calendar date. Month lengths and leap years are handled, and the hours register can be kept in either 24-hour or 12-hour (AM/PM) form.

A host loads any field through a synchronous write port and reads any field through a combinational read port. Bit 7 of the seconds register freezes the counter. Any write to the seconds register restarts the sub-second prescaler, so the first tick after that write comes a full second later.

Register addresses: 0 seconds (bit 7 = halt, bits 6:0 BCD 00–59), 1 minutes, 2 hours, 3 weekday, 4 date, 5 month, 6 year. Address 7 reads as zero.

Top module: `rtc_bcd_clock`

## Requirements
- R1: Seconds and minutes count in BCD from 00 to 59. Going past 59 gives 00 and carries one into the next field. A ones digit of 9 carries into the tens digit (09→10).
- R2: With hours bit 6 = 0 (24-hour), hours bits 5:0 count BCD 00–23. The step from 23 goes to 00 and advances the date.
- R3: With hours bit 6 = 1 (12-hour), bits 4:0 hold BCD 01–12 and bit 5 = 1 means PM. The sequence is 09→10, 11 AM→12 PM, 12 PM→01 PM, and 11 PM→12 AM. Only 11 PM→12 AM advances the date. Bit 6 is preserved.
- R4: The date rolls to 01 after day 30 in months 04, 06, 09 and 11, after day 31 in the other months, and after day 28 in February. In a leap year February ends at 29 instead. A year is a leap year when its value is divisible by 4, and year 00 counts as a leap year.
- R5: The weekday (1–7) changes only when the date advances at midnight, and it wraps from 7 to 1.
- R6: The month goes 12→01 and carries into the year. The year counts BCD 00–99 and wraps to 00.
- R7: While seconds bit 7 = 1, no field changes except through host writes. Clearing the bit resumes counting.
- R8: `sec_tick` is high for one cycle on the cycle in which the 2^PRESC_BITS-th `osc_en` pulse since the last restart is seen. Seconds advance on that clock edge. Cycles without `osc_en` do not count.
- R9: A write to address 0 restarts the prescaler. After such a write, exactly 2^PRESC_BITS further `osc_en` pulses are needed before the next tick.
- R10: Bits that are fixed at zero read back as 0 whatever was written. The fixed-zero bits are minutes bit 7, hours bit 7, weekday bits 7:3, date bits 7:6 and month bits 7:5. Address 7 reads 0.
- R11: After reset the registers read: seconds 00 with halt 0, minutes 00, hours 00 in 24-hour form, weekday 1, date 01, month 01, year 00.
- R12: A write loads its field on the next clock edge. When a write and a tick fall on the same edge, the written field takes the written value and the other fields still advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset to the power-on values |
| osc_en | input | 1 | One-cycle enable per 32.768 kHz reference period |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | 3 | Register address of the write |
| wr_data | input | 8 | Write data |
| rd_addr | input | 3 | Register address of the read |
| rd_data | output | 8 | Contents of the register selected by rd_addr |
| sec_tick | output | 1 | One-cycle pulse on each one-second step |

## Verification
The bench drives the counter through every rollover boundary: the end of the year at midnight, each short month, February with year 24, 23 and 00, and the four 12-hour transitions around noon and midnight. Common faults have visible results. A design that toggles PM at 12→01 shows 01 AM at one in the afternoon, and one that treats year 00 as a common year jumps from 28 February to 1 March. The bench also makes two timing checks: it places a seconds write partway through a second and confirms the next tick comes a full period later, and it lands a minutes write on the tick edge to confirm the write wins without stopping the seconds. Halt, the masking of fixed-zero bits and the reset values are each checked at the read port.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    localparam int FIELD_W = 8;
    localparam int ADDR_W  = 3;

    typedef enum logic [ADDR_W-1:0] {
        RA_SEC  = 3'd0,
        RA_MIN  = 3'd1,
        RA_HOUR = 3'd2,
        RA_DOW  = 3'd3,
        RA_DATE = 3'd4,
        RA_MON  = 3'd5,
        RA_YEAR = 3'd6,
        RA_NONE = 3'd7
    } rtc_addr_e;

    typedef struct packed {
        logic [FIELD_W-1:0] sec;
        logic [FIELD_W-1:0] min;
        logic [FIELD_W-1:0] hour;
        logic [FIELD_W-1:0] dow;
        logic [FIELD_W-1:0] date;
        logic [FIELD_W-1:0] mon;
        logic [FIELD_W-1:0] year;
    } rtc_time_t;

    localparam rtc_time_t POR_TIME = '{
        sec:  8'h00, min:  8'h00, hour: 8'h00, dow: 8'h01,
        date: 8'h01, mon:  8'h01, year: 8'h00
    };

    // Two-digit BCD increment, no wrap handling.
    function automatic logic [FIELD_W-1:0] bcd_inc(input logic [FIELD_W-1:0] v);
        if (v[3:0] == 4'h9)
            return {v[7:4] + 4'h1, 4'h0};
        else
            return {v[7:4], v[3:0] + 4'h1};
    endfunction

    // Bits that may hold a one in each register.
    function automatic logic [FIELD_W-1:0] field_mask(input logic [ADDR_W-1:0] a);
        case (rtc_addr_e'(a))
            RA_SEC:  return 8'hFF;
            RA_MIN:  return 8'h7F;
            RA_HOUR: return 8'h7F;
            RA_DOW:  return 8'h07;
            RA_DATE: return 8'h3F;
            RA_MON:  return 8'h1F;
            RA_YEAR: return 8'hFF;
            default: return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
    parameter int PRESC_BITS = 15
) (
    input  logic clk,
    input  logic rst_n,
    input  logic osc_en,
    input  logic run_i,
    input  logic clear_i,
    output logic tick_o
);

    localparam logic [PRESC_BITS-1:0] CNT_LAST = {PRESC_BITS{1'b1}};

    typedef struct packed {
        logic [PRESC_BITS-1:0] cnt;
    } presc_state_t;

    presc_state_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        tick_o = 1'b0;
        if (clear_i) begin
            st_d.cnt = '0;
        end else if (run_i && osc_en) begin
            st_d.cnt = st_q.cnt + 1'b1;
            tick_o   = (st_q.cnt == CNT_LAST);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R8
    tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);

    // R9
    clear_notick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> !tick_o);

endmodule

// File: rtl/rtc_hour_step.sv
module rtc_hour_step
    import rtc_pkg::*;
(
    input  logic [FIELD_W-1:0] hour_i,
    output logic [FIELD_W-1:0] hour_o,
    output logic               day_carry_o
);

    logic               mode12;
    logic               pm;
    logic [FIELD_W-1:0] h12;
    logic [FIELD_W-1:0] h24;

    assign mode12 = hour_i[6];
    assign pm     = hour_i[5];
    assign h12    = {3'b000, hour_i[4:0]};
    assign h24    = {2'b00, hour_i[5:0]};

    always_comb begin
        hour_o      = 8'h00;
        day_carry_o = 1'b0;
        if (mode12) begin
            if (h12 == 8'h12) begin
                hour_o = {2'b01, pm, 5'h01};
            end else if (h12 == 8'h11) begin
                hour_o      = {2'b01, ~pm, 5'h12};
                day_carry_o = pm;
            end else begin
                hour_o = {2'b01, pm, bcd_inc(h12)[4:0]};
            end
        end else begin
            if (h24 == 8'h23) begin
                hour_o      = 8'h00;
                day_carry_o = 1'b1;
            end else begin
                hour_o = {2'b00, bcd_inc(h24)[5:0]};
            end
        end
    end

endmodule

// File: rtl/rtc_month_limit.sv
module rtc_month_limit
    import rtc_pkg::*;
(
    input  logic [FIELD_W-1:0] mon_i,
    input  logic [FIELD_W-1:0] year_i,
    output logic [FIELD_W-1:0] last_o
);

    logic [6:0] year_bin;
    logic       leap;

    assign year_bin = 7'(year_i[7:4]) * 7'd10 + 7'(year_i[3:0]);
    assign leap     = (year_bin[1:0] == 2'b00);

    always_comb begin
        case (mon_i)
            8'h04, 8'h06, 8'h09, 8'h11: last_o = 8'h30;
            8'h02:                      last_o = leap ? 8'h29 : 8'h28;
            default:                    last_o = 8'h31;
        endcase
    end

endmodule

// File: rtl/rtc_timekeeper.sv
module rtc_timekeeper
    import rtc_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [FIELD_W-1:0] wr_data,
    output rtc_time_t          time_o
);

    rtc_time_t          tm_d, tm_q;
    logic [FIELD_W-1:0] hour_nx;
    logic               day_carry;
    logic [FIELD_W-1:0] last_date;
    logic               c_min, c_hour, c_mon, c_year;
    logic [FIELD_W-1:0] wval;

    rtc_hour_step u_hour (
        .hour_i      (tm_q.hour),
        .hour_o      (hour_nx),
        .day_carry_o (day_carry)
    );

    rtc_month_limit u_limit (
        .mon_i  (tm_q.mon),
        .year_i (tm_q.year),
        .last_o (last_date)
    );

    assign wval = wr_data & field_mask(wr_addr);

    always_comb begin
        tm_d   = tm_q;
        c_min  = 1'b0;
        c_hour = 1'b0;
        c_mon  = 1'b0;
        c_year = 1'b0;

        if (tick) begin
            if (tm_q.sec[6:0] == 7'h59) begin
                tm_d.sec = {tm_q.sec[7], 7'h00};
                c_min    = 1'b1;
            end else begin
                tm_d.sec = {tm_q.sec[7], bcd_inc({1'b0, tm_q.sec[6:0]})[6:0]};
            end

            if (c_min) begin
                if (tm_q.min == 8'h59) begin
                    tm_d.min = 8'h00;
                    c_hour   = 1'b1;
                end else begin
                    tm_d.min = bcd_inc(tm_q.min);
                end
            end

            if (c_hour) begin
                tm_d.hour = hour_nx;
                if (day_carry) begin
                    tm_d.dow = (tm_q.dow == 8'h07) ? 8'h01 : tm_q.dow + 8'h01;
                    if (tm_q.date == last_date) begin
                        tm_d.date = 8'h01;
                        c_mon     = 1'b1;
                    end else begin
                        tm_d.date = bcd_inc(tm_q.date);
                    end
                end
            end

            if (c_mon) begin
                if (tm_q.mon == 8'h12) begin
                    tm_d.mon = 8'h01;
                    c_year   = 1'b1;
                end else begin
                    tm_d.mon = bcd_inc(tm_q.mon);
                end
            end

            if (c_year)
                tm_d.year = (tm_q.year == 8'h99) ? 8'h00 : bcd_inc(tm_q.year);
        end

        if (wr_en) begin
            case (rtc_addr_e'(wr_addr))
                RA_SEC:  tm_d.sec  = wval;
                RA_MIN:  tm_d.min  = wval;
                RA_HOUR: tm_d.hour = wval;
                RA_DOW:  tm_d.dow  = wval;
                RA_DATE: tm_d.date = wval;
                RA_MON:  tm_d.mon  = wval;
                RA_YEAR: tm_d.year = wval;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tm_q <= POR_TIME;
        else        tm_q <= tm_d;
    end

    assign time_o = tm_q;

    // R1
    sec_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !wr_en && tm_q.sec[6:0] == 7'h59) |=> (tm_q.sec[6:0] == 7'h00));

    // R7
    halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tm_q.sec[7] && !wr_en) |=> $stable(tm_q));

    // R5
    dow_midnight_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && tm_q.sec[6:0] != 7'h59) |=> $stable(tm_q.dow));

    // R12
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !wr_en) |=> $stable(tm_q));

endmodule

// File: rtl/rtc_bcd_clock.sv
module rtc_bcd_clock
    import rtc_pkg::*;
#(
    parameter int PRESC_BITS = 15
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        osc_en,
    input  logic        wr_en,
    input  logic [2:0]  wr_addr,
    input  logic [7:0]  wr_data,
    input  logic [2:0]  rd_addr,
    output logic [7:0]  rd_data,
    output logic        sec_tick
);

    rtc_time_t tm;
    logic      sec_write;

    assign sec_write = wr_en && (rtc_addr_e'(wr_addr) == RA_SEC);

    rtc_prescaler #(.PRESC_BITS(PRESC_BITS)) u_presc (
        .clk     (clk),
        .rst_n   (rst_n),
        .osc_en  (osc_en),
        .run_i   (~tm.sec[7]),
        .clear_i (sec_write),
        .tick_o  (sec_tick)
    );

    rtc_timekeeper u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (sec_tick),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .time_o  (tm)
    );

    always_comb begin
        case (rtc_addr_e'(rd_addr))
            RA_SEC:  rd_data = tm.sec;
            RA_MIN:  rd_data = tm.min;
            RA_HOUR: rd_data = tm.hour;
            RA_DOW:  rd_data = tm.dow;
            RA_DATE: rd_data = tm.date;
            RA_MON:  rd_data = tm.mon;
            RA_YEAR: rd_data = tm.year;
            default: rd_data = 8'h00;
        endcase
    end

endmodule

// File: tb/tb_rtc_bcd_clock.sv
module tb_rtc_bcd_clock;

    localparam int CLK_PERIOD = 10;
    localparam int PB         = 4;
    localparam int TICK_LEN   = 1 << PB;
    localparam int NV         = 15;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       osc_en = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = 3'd0;
    logic [7:0] wr_data = 8'h00;
    logic [2:0] rd_addr = 3'd0;
    logic [7:0] rd_data;
    logic       sec_tick;

    int tests = 0;
    int fails = 0;

    rtc_bcd_clock #(.PRESC_BITS(PB)) dut (
        .clk(clk), .rst_n(rst_n), .osc_en(osc_en), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .rd_data(rd_data), .sec_tick(sec_tick)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // {req, sec, min, hour, dow, date, mon, year, expected x7 after one tick}
    localparam logic [119:0] VEC [NV] = '{
        {8'd2, 56'h59592307311299, 56'h00000001010100}, // R2 R5 R6 end of year
        {8'd3, 56'h59595102150620, 56'h00007202150620}, // R3 11 AM -> 12 PM
        {8'd3, 56'h59597103280223, 56'h00005204010323}, // R3 R4 11 PM -> 12 AM, Feb common
        {8'd3, 56'h59597205100721, 56'h00006105100721}, // R3 12 PM -> 01 PM
        {8'd4, 56'h59592304280224, 56'h00000005290224}, // R4 leap Feb 28
        {8'd4, 56'h59592306280200, 56'h00000007290200}, // R4 year 00 is leap
        {8'd4, 56'h59592301300425, 56'h00000002010525}, // R4 30-day month
        {8'd6, 56'h59592302300925, 56'h00000003011025}, // R6 R4 month 09 -> 10
        {8'd1, 56'h59590903120325, 56'h00001003120325}, // R1 R2 hour 09 -> 10
        {8'd4, 56'h59592304300125, 56'h00000005310125}, // R4 31-day month, no wrap
        {8'd6, 56'h59592305311209, 56'h00000006010110}, // R6 year 09 -> 10
        {8'd1, 56'h29451402030325, 56'h30451402030325}, // R1 plain seconds step
        {8'd1, 56'h59090802030325, 56'h00100802030325}, // R1 minutes 09 -> 10
        {8'd3, 56'h59594902030325, 56'h00005002030325}, // R3 09 AM -> 10 AM
        {8'd5, 56'h59592304290224, 56'h00000005010324}  // R5 R4 leap Feb 29 -> Mar 01
    };

    task automatic chk(input int req, input string what, input logic [7:0] got, input logic [7:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL R%0d %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic run(input int n);
        @(negedge clk);
        osc_en = 1'b1;
        repeat (n) @(negedge clk);
        osc_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        $display("FAIL R12 watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R11 power-on values
        rd(3'd0, v); chk(11, "por sec",  v, 8'h00);
        rd(3'd1, v); chk(11, "por min",  v, 8'h00);
        rd(3'd2, v); chk(11, "por hour", v, 8'h00);
        rd(3'd3, v); chk(11, "por dow",  v, 8'h01);
        rd(3'd4, v); chk(11, "por date", v, 8'h01);
        rd(3'd5, v); chk(11, "por mon",  v, 8'h01);
        rd(3'd6, v); chk(11, "por year", v, 8'h00);

        // Vector table: load, one tick, compare all fields
        for (int i = 0; i < NV; i++) begin
            logic [119:0] vec;
            vec = VEC[i];
            for (int f = 0; f < 7; f++) wr(3'(f), vec[111 - 8*f -: 8]);
            run(TICK_LEN);
            for (int f = 0; f < 7; f++) begin
                rd(3'(f), v);
                chk(int'(vec[119:112]), $sformatf("vec %0d field %0d", i, f), v, vec[55 - 8*f -: 8]);
            end
        end

        // R8 tick lands on the 2^PB-th enable; idle cycles do not count
        wr(3'd0, 8'h00);
        repeat (30) @(negedge clk);
        @(negedge clk);
        osc_en = 1'b1;
        repeat (TICK_LEN - 2) @(negedge clk);
        chk(8, "tick early", {7'd0, sec_tick}, 8'h00);
        @(negedge clk);
        chk(8, "tick on last enable", {7'd0, sec_tick}, 8'h01);
        @(negedge clk);
        osc_en = 1'b0;
        rd(3'd0, v); chk(8, "sec after tick", v, 8'h01);

        // R9 seconds write restarts the prescaler mid-second
        run(10);
        wr(3'd0, 8'h20);
        run(TICK_LEN - 1);
        rd(3'd0, v); chk(9, "no tick before full period", v, 8'h20);
        run(1);
        rd(3'd0, v); chk(9, "tick after full period", v, 8'h21);

        // R7 halt freezes, clearing resumes
        wr(3'd0, 8'h90);
        run(3 * TICK_LEN);
        rd(3'd0, v); chk(7, "halted sec", v, 8'h90);
        wr(3'd0, 8'h10);
        run(TICK_LEN);
        rd(3'd0, v); chk(7, "resumed sec", v, 8'h11);

        // R10 fixed-zero bits and unused address
        wr(3'd3, 8'hFF); rd(3'd3, v); chk(10, "dow mask", v, 8'h07);
        wr(3'd5, 8'hFF); rd(3'd5, v); chk(10, "mon mask", v, 8'h1F);
        wr(3'd1, 8'hFF); rd(3'd1, v); chk(10, "min mask", v, 8'h7F);
        wr(3'd4, 8'hFF); rd(3'd4, v); chk(10, "date mask", v, 8'h3F);
        wr(3'd7, 8'hFF); rd(3'd7, v); chk(10, "addr 7", v, 8'h00);

        // R12 write and tick on the same edge
        wr(3'd1, 8'h12);
        wr(3'd0, 8'h59);
        @(negedge clk);
        osc_en = 1'b1;
        repeat (TICK_LEN - 1) @(negedge clk);
        wr_en = 1'b1; wr_addr = 3'd1; wr_data = 8'h30;
        @(negedge clk);
        wr_en = 1'b0; osc_en = 1'b0;
        rd(3'd1, v); chk(12, "written min wins", v, 8'h30);
        rd(3'd0, v); chk(12, "sec still advances", v, 8'h00);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule